// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates an address by walking a multi-level radix tree held in memory. A request carries the address to translate and one 64-bit root descriptor word. That word gives the base of the top directory, the index width used at the top level, and the total address-space size in bits. The walker reads one 64-bit entry per level over a plain request/response memory port. At each directory entry it narrows the remaining size and moves down a level. It stops when it reaches a leaf entry or finds a problem.

When the walk succeeds, the walker returns three things: the real address, the page size in bits, and the leaf entry itself. When it fails, it raises a fault pulse with a two-bit cause. The tree shapes it accepts are fixed:

- The top level must cover 52 bits and index with 13 bits.
- The second level and the fourth level index with 9 bits.
- The third level indexes with 9 or 5 bits.
- A walk may not go beyond four levels.

The block handles one walk at a time and goes back to idle after every outcome. Process-table lookup, nested translation and permission checks are left to the blocks around it.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `done`, `fault` and `mem_req_valid` are all low, and they stay low until a request arrives.
- R2: The root word is decoded as follows. The directory base is bits 59:8 with eight zero bits appended. The index width is bits 4:0. The size is 31 plus a 5-bit value whose upper two bits are word bits 62:61 and whose lower three bits are word bits 7:5. At the top level, any size other than 52, or any index width other than 13, faults with cause 2 (bad configuration) and makes no memory read.
- R3: At each level the index is (address >> (size − width)) masked to `width` bits. The entry is read at base + 8 × index. The size left for the next level is size − width.
- R4: A table base that is not a multiple of 2^(width+3) bytes faults with cause 3 (misaligned). The alignment check is made before the configuration check, and no read is made for that level.
- R5: An entry whose bit 63 (valid) is clear faults with cause 1 (no entry).
- R6: A valid entry with bit 62 (leaf) clear is a directory entry. Its base is bits 59:8 with eight zero bits appended, and its width is bits 4:0. The second and fourth levels accept only width 9. The third level accepts width 9 or 5. A fifth level always faults with cause 2.
- R7: A valid leaf entry completes the walk with cause 0. The page size is the size left after the last directory. The real address is the page number from entry bits 56:12, with its low page-size bits replaced by the same bits of the input address. The leaf word is returned unchanged.
- R8: Only one read is outstanding at a time. `mem_req_valid` stays high with a stable address until `mem_rsp_valid` is seen, and it drops in the next cycle. A walk of n reads with a response latency of L cycles ends n·(L+3) cycles after the request is accepted, or one cycle later when it ends on a level check.
- R9: `done` and `fault` are single-cycle pulses and never occur together. A request input held high during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_va | input | 64 | Address to translate |
| req_root | input | 64 | Root descriptor word |
| mem_req_valid | output | 1 | Entry read request, held until response |
| mem_req_addr | output | 64 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry word returned |
| done | output | 1 | One-cycle pulse: walk found a leaf |
| fault | output | 1 | One-cycle pulse: walk failed |
| out_cause | output | 2 | 0 none, 1 no entry, 2 bad configuration, 3 misaligned |
| out_raddr | output | 64 | Translated real address |
| out_psize | output | 6 | Page size in bits |
| out_pte | output | 64 | Leaf entry word |

## Verification
The hardest outcomes to reach from the ports are the deep ones. These are a walk that runs past its fourth level, a misaligned base or wrong width found three levels down, and an invalid entry partway along the path. Each needs a consistent chain of directory entries in memory that leads exactly to the offending point. The bench builds each path by working out, from the chosen address, the entry slot that every level will index. It then places directory words or a deliberately bad word there. A behavioural model predicts each outcome, the exact read addresses and the cycle of the final pulse, under two response latencies.

// File: rtl/radix_walk_pkg.sv
// Shared types and helpers for the radix tree walker.
// Assumes 64-bit entries with fixed field positions.
package radix_walk_pkg;

    localparam int WORD_W = 64;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_NO_ENTRY = 2'd1,
        CAUSE_BAD_CFG  = 2'd2,
        CAUSE_MISALIGN = 2'd3
    } walk_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT,
        ST_EVAL
    } walk_state_e;

    // Root size: 31 plus a value split over word bits 62:61 and 7:5
    function automatic logic [5:0] root_size(input logic [WORD_W-1:0] w);
        return 6'd31 + {1'b0, w[62:61], w[7:5]};
    endfunction

    // Table base held in bits 59:8 of a root or directory word
    function automatic logic [WORD_W-1:0] table_base(input logic [WORD_W-1:0] w);
        return {4'b0, w[59:8], 8'b0};
    endfunction

endpackage

// File: rtl/rw_step_calc.sv
// Per-level step logic (combinational). It checks base alignment and
// size legality for the current level, and computes the entry address
// and the remaining size. Assumes size >= nls whenever legal is set.
module rw_step_calc #(
    parameter int LVL_W       = 3,
    parameter int LEVEL_LIMIT = 4,
    parameter int ROOT_SIZE   = 52,
    parameter int ROOT_NLS    = 13,
    parameter int WIDE_NLS    = 9,
    parameter int NARROW_NLS  = 5
) (
    input  logic [63:0]      va,
    input  logic [63:0]      base,
    input  logic [4:0]       nls,
    input  logic [5:0]       size,
    input  logic [LVL_W-1:0] level,
    output logic             misaligned,
    output logic             bad_cfg,
    output logic [63:0]      entry_addr,
    output logic [5:0]       size_next
);
    logic [5:0]  align_sh;
    logic [63:0] align_mask;
    logic [63:0] idx;
    logic        legal;

    // Alignment: base must be a multiple of the table byte size
    always_comb begin
        align_sh   = {1'b0, nls} + 6'd3;
        align_mask = (64'd1 << align_sh) - 64'd1;
        misaligned = |(base & align_mask);
    end

    // Legality of the (level, size, nls) combination
    always_comb begin
        if (level == LVL_W'(0))
            legal = (size == 6'(ROOT_SIZE)) && (nls == 5'(ROOT_NLS));
        else if (level == LVL_W'(1) || level == LVL_W'(3))
            legal = (nls == 5'(WIDE_NLS));
        else if (level == LVL_W'(2))
            legal = (nls == 5'(WIDE_NLS)) || (nls == 5'(NARROW_NLS));
        else
            legal = 1'b0;
        if (int'(level) >= LEVEL_LIMIT)
            legal = 1'b0;
        bad_cfg = !legal;
    end

    // Index extraction and entry address
    always_comb begin
        size_next  = size - {1'b0, nls};
        idx        = (va >> size_next) & ((64'd1 << nls) - 64'd1);
        entry_addr = base + (idx << 3);
    end

endmodule

// File: rtl/rw_leaf_merge.sv
// Forms the real address from a leaf page number and the input address:
// bits below psize come from the address, the rest from the page number.
module rw_leaf_merge (
    input  logic [63:0] va,
    input  logic [44:0] rpn,
    input  logic [5:0]  psize,
    output logic [63:0] raddr
);
    logic [63:0] rpn_word;

    // Page number placed at byte position 12
    assign rpn_word = {7'b0, rpn, 12'b0};

    for (genvar i = 0; i < 64; i++) begin : g_bit
        // Per bit: offset bit from address, else page number bit
        assign raddr[i] = (psize > 6'(i)) ? va[i] : rpn_word[i];
    end

endmodule

// File: rtl/radix_walker.sv
// Sequential radix tree walker. It takes one request at a time while
// idle, reads one entry per level, and pulses done or fault for one
// cycle before returning to idle. Memory must hold the response until
// it is taken, and must answer only while mem_req_valid is high.
module radix_walker
    import radix_walk_pkg::*;
#(
    parameter int LEVEL_LIMIT = 4,
    parameter int ROOT_SIZE   = 52,
    parameter int ROOT_NLS    = 13,
    parameter int WIDE_NLS    = 9,
    parameter int NARROW_NLS  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [63:0] req_va,
    input  logic [63:0] req_root,
    output logic        mem_req_valid,
    output logic [63:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    output logic        done,
    output logic        fault,
    output logic [1:0]  out_cause,
    output logic [63:0] out_raddr,
    output logic [5:0]  out_psize,
    output logic [63:0] out_pte
);
    localparam int LVL_W = $clog2(LEVEL_LIMIT + 1);

    walk_state_e      state;
    walk_cause_e      cause_q;
    logic [LVL_W-1:0] level;
    logic [63:0]      cur_va;
    logic [63:0]      cur_base;
    logic [4:0]       cur_nls;
    logic [5:0]       cur_size;
    logic [63:0]      fetch_addr;
    logic [63:0]      entry_q;

    logic             step_misaligned;
    logic             step_bad_cfg;
    logic [63:0]      step_addr;
    logic [5:0]       step_size;
    logic [63:0]      leaf_raddr;
    logic             unused_root_bits;

    assign unused_root_bits = ^{req_root[63], req_root[60]};

    rw_step_calc #(
        .LVL_W      (LVL_W),
        .LEVEL_LIMIT(LEVEL_LIMIT),
        .ROOT_SIZE  (ROOT_SIZE),
        .ROOT_NLS   (ROOT_NLS),
        .WIDE_NLS   (WIDE_NLS),
        .NARROW_NLS (NARROW_NLS)
    ) u_step (
        .va        (cur_va),
        .base      (cur_base),
        .nls       (cur_nls),
        .size      (cur_size),
        .level     (level),
        .misaligned(step_misaligned),
        .bad_cfg   (step_bad_cfg),
        .entry_addr(step_addr),
        .size_next (step_size)
    );

    rw_leaf_merge u_leaf (
        .va   (cur_va),
        .rpn  (entry_q[56:12]),
        .psize(cur_size),
        .raddr(leaf_raddr)
    );

    // Memory port: request held for the whole wait state
    assign mem_req_valid = (state == ST_WAIT);
    assign mem_req_addr  = fetch_addr;
    assign out_cause     = cause_q;

    // Walk state machine and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cause_q    <= CAUSE_NONE;
            level      <= '0;
            cur_va     <= '0;
            cur_base   <= '0;
            cur_nls    <= '0;
            cur_size   <= '0;
            fetch_addr <= '0;
            entry_q    <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            out_raddr  <= '0;
            out_psize  <= '0;
            out_pte    <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur_va   <= req_va;
                        cur_base <= table_base(req_root);
                        cur_nls  <= req_root[4:0];
                        cur_size <= root_size(req_root);
                        level    <= '0;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (step_misaligned) begin
                        fault   <= 1'b1;
                        cause_q <= CAUSE_MISALIGN;
                        state   <= ST_IDLE;
                    end else if (step_bad_cfg) begin
                        fault   <= 1'b1;
                        cause_q <= CAUSE_BAD_CFG;
                        state   <= ST_IDLE;
                    end else begin
                        fetch_addr <= step_addr;
                        cur_size   <= step_size;
                        state      <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        entry_q <= mem_rsp_data;
                        state   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (!entry_q[63]) begin
                        fault   <= 1'b1;
                        cause_q <= CAUSE_NO_ENTRY;
                        state   <= ST_IDLE;
                    end else if (entry_q[62]) begin
                        done      <= 1'b1;
                        cause_q   <= CAUSE_NONE;
                        out_raddr <= leaf_raddr;
                        out_psize <= cur_size;
                        out_pte   <= entry_q;
                        state     <= ST_IDLE;
                    end else begin
                        cur_base <= table_base(entry_q);
                        cur_nls  <= entry_q[4:0];
                        level    <= level + LVL_W'(1);
                        state    <= ST_CHECK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/radix_walker_chk.sv
// Protocol and outcome checks for radix_walker, bound to every instance.
module radix_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_valid,
    input logic [63:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic        done,
    input logic        fault,
    input logic [1:0]  out_cause,
    input logic [63:0] out_pte
);
    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    assert_hold_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_drop_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_rsp_valid) |=> !mem_req_valid);

    assert_entry_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    assert_leaf_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_pte[63] && out_pte[62] && out_cause == 2'd0));

    assert_fault_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (out_cause != 2'd0));

endmodule

bind radix_walker radix_walker_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .done         (done),
    .fault        (fault),
    .out_cause    (out_cause),
    .out_pte      (out_pte)
);

// File: tb/test_radix_walker.sv
// Bench for radix_walker: a behavioural walk model predicts the outcome,
// the read addresses and the pulse cycle; outputs are compared each cycle.
module test_radix_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [63:0] req_root = '0;
    logic        mem_req_valid;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, fault;
    logic [1:0]  out_cause;
    logic [63:0] out_raddr, out_pte;
    logic [5:0]  out_psize;

    bit [63:0] mem [bit [63:0]];
    bit [63:0] exp_q [$];
    int lat = 0;
    int rd_cnt = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ended = 0;

    localparam bit [63:0] B0 = 64'h0010_0000;
    localparam bit [63:0] B1 = 64'h0020_0000;
    localparam bit [63:0] B2 = 64'h0030_0000;
    localparam bit [63:0] B3 = 64'h0040_0000;
    localparam bit [63:0] B4 = 64'h0050_0000;

    always #5 clk = ~clk;

    radix_walker i_radix_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_root(req_root), .mem_req_valid(mem_req_valid),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .out_cause(out_cause), .out_raddr(out_raddr), .out_psize(out_psize),
        .out_pte(out_pte)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input bit [63:0] act, input bit [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    // Memory: answer after lat extra cycles, verify each read address (R3)
    always @(negedge clk) begin
        if (mem_req_valid) begin
            if (rd_cnt == lat) begin
                rd_cnt = 0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
                if (exp_q.size() > 0) begin
                    chk(mem_req_addr == exp_q[0], "R3", "entry address", mem_req_addr, exp_q[0]);
                    void'(exp_q.pop_front());
                end else
                    chk(1'b0, "R8", "unexpected read", mem_req_addr, 64'h0);
            end else begin
                rd_cnt++;
                mem_rsp_valid = 1'b0;
            end
        end else begin
            rd_cnt = 0;
            mem_rsp_valid = 1'b0;
        end
    end

    function automatic bit [63:0] dir_w(bit [63:0] base, int nls);
        return {1'b1, 1'b0, 2'b0, base[59:8], 3'b0, 5'(nls)};
    endfunction

    function automatic bit [63:0] leaf_w(bit [63:0] rpn_addr);
        return {1'b1, 1'b1, 5'b0, rpn_addr[56:12], 12'h18F};
    endfunction

    function automatic bit [63:0] root_w(bit [63:0] base, int size, int nls);
        bit [4:0] s = 5'(size - 31);
        return {1'b0, s[4:3], 1'b0, base[59:8], s[2:0], 5'(nls)};
    endfunction

    // Behavioural reference walk
    task automatic model(input bit [63:0] va, input bit [63:0] root,
                         output bit is_fault, output bit [1:0] cause,
                         output bit [63:0] ra, output int ps,
                         output bit [63:0] pte, output int edges);
        int size, nls, lvl, reads;
        bit [63:0] base, idx, a, e, mask;
        bit legal;
        size = 31 + int'({root[62:61], root[7:5]});
        nls = int'(root[4:0]);
        base = {4'b0, root[59:8], 8'b0};
        lvl = 0; reads = 0; ra = 0; ps = 0; pte = 0;
        while (1) begin
            if ((base % (64'd1 << (nls + 3))) != 0) begin
                is_fault = 1; cause = 3; edges = reads * (lat + 3) + 1; return;
            end
            case (lvl)
                0: legal = (size == 52 && nls == 13);
                1, 3: legal = (nls == 9);
                2: legal = (nls == 9 || nls == 5);
                default: legal = 0;
            endcase
            if (!legal) begin
                is_fault = 1; cause = 2; edges = reads * (lat + 3) + 1; return;
            end
            idx = (va >> (size - nls)) & ((64'd1 << nls) - 1);
            a = base + idx * 8;
            exp_q.push_back(a);
            size = size - nls;
            reads++;
            e = mem.exists(a) ? mem[a] : 64'h0;
            if (!e[63]) begin
                is_fault = 1; cause = 1; edges = reads * (lat + 3); return;
            end
            if (e[62]) begin
                mask = (64'd1 << size) - 1;
                ra = ({7'b0, e[56:12], 12'b0} & ~mask) | (va & mask);
                ps = size; pte = e; is_fault = 0; cause = 0;
                edges = reads * (lat + 3); return;
            end
            base = {4'b0, e[59:8], 8'b0};
            nls = int'(e[4:0]);
            lvl++;
        end
    endtask

    // Place a path in memory: nl[] per level, leaf at leaf_at (or chain on)
    task automatic build(input bit [63:0] va, input int n1, input int n2,
                         input int n3, input int leaf_at, input bit [63:0] lw,
                         input bit [63:0] lvl2_base);
        bit [63:0] bases [5];
        int nl [5];
        int size, sh;
        bit [63:0] a;
        bases[0] = B0; bases[1] = B1; bases[2] = lvl2_base; bases[3] = B3; bases[4] = B4;
        nl[0] = 13; nl[1] = n1; nl[2] = n2; nl[3] = n3; nl[4] = 9;
        mem.delete();
        size = 52;
        for (int l = 0; l < 4; l++) begin
            sh = size - nl[l];
            a = bases[l] + ((va >> sh) & ((64'd1 << nl[l]) - 1)) * 8;
            size = sh;
            if (l == leaf_at) begin
                mem[a] = lw;
                break;
            end
            mem[a] = dir_w(bases[l + 1], nl[l + 1]);
        end
    endtask

    // One walk, compared on every cycle until one past the outcome
    task automatic run_walk(input bit [63:0] va, input bit [63:0] root,
                            input string rq, input bit hold);
        bit is_f; bit [1:0] c; bit [63:0] ra, pte; int ps, edges;
        model(va, root, is_f, c, ra, ps, pte, edges);
        @(negedge clk);
        req_valid = 1; req_va = va; req_root = root;
        @(posedge clk); @(negedge clk);
        if (hold) begin
            req_root = ~root; req_va = ~va;
        end else req_valid = 0;
        for (int i = 1; i <= edges + 1; i++) begin
            @(posedge clk); @(negedge clk);
            chk(done == (i == edges && !is_f), "R9 R8", "done timing", 64'(done), 64'(i == edges && !is_f));
            chk(fault == (i == edges && is_f), "R9 R8", "fault timing", 64'(fault), 64'(i == edges && is_f));
            if (i == edges) begin
                if (hold) req_valid = 0;
                chk(out_cause == c, rq, "cause", 64'(out_cause), 64'(c));
                if (!is_f) begin
                    chk(out_raddr == ra, rq, "raddr", out_raddr, ra);
                    chk(out_psize == 6'(ps), rq, "psize", 64'(out_psize), 64'(ps));
                    chk(out_pte == pte, rq, "pte", out_pte, pte);
                end
            end
        end
        chk(exp_q.size() == 0, "R8", "reads left", 64'(exp_q.size()), 64'h0);
        exp_q.delete();
    endtask

    initial begin
        bit [63:0] va1, va2, r52;
        va1 = 64'h0003_2A5F_1B37_9ABC;
        va2 = 64'hF00C_D135_7E24_6AD1;
        r52 = root_w(B0, 52, 13);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            chk(!done && !fault && !mem_req_valid, "R1", "idle after reset",
                64'({done, fault, mem_req_valid}), 64'h0);
        end
        // R7 R3: four-level walk to 4K page, two latencies (R8)
        lat = 0; build(va1, 9, 9, 9, 3, leaf_w(64'h00AB_CDEF_0000), B2);
        run_walk(va1, r52, "R7", 0);
        lat = 3; build(va2, 9, 9, 9, 3, leaf_w(64'h0123_4567_8000), B2);
        run_walk(va2, r52, "R3", 0);
        // R7: leaf at second level, 30-bit page
        lat = 1; build(va1, 9, 9, 9, 1, leaf_w(64'h01F0_C000_0000), B2);
        run_walk(va1, r52, "R7", 0);
        // R6: width 5 at third level, leaf at fourth (16-bit page)
        build(va2, 9, 5, 9, 3, leaf_w(64'h0000_7777_0000), B2);
        run_walk(va2, r52, "R6", 0);
        // R6: leaf at third level with width 5 (25-bit page)
        build(va1, 9, 5, 9, 2, leaf_w(64'h0055_AE00_0000), B2);
        run_walk(va1, r52, "R6", 0);
        // R6: illegal widths at second and fourth level, and fifth level
        build(va1, 5, 9, 9, 3, leaf_w(64'h0), B2);
        run_walk(va1, r52, "R6", 0);
        build(va2, 9, 9, 5, 3, leaf_w(64'h0), B2);
        run_walk(va2, r52, "R6", 0);
        lat = 2; build(va1, 9, 9, 9, 9, leaf_w(64'h0), B2);
        run_walk(va1, r52, "R6", 0);
        // R2: wrong root size and wrong root width
        mem.delete();
        run_walk(va1, root_w(B0, 48, 13), "R2", 0);
        run_walk(va1, root_w(B0, 52, 12), "R2", 0);
        // R4: misaligned root base, misaligned third-level base
        run_walk(va1, root_w(64'h0010_8000, 52, 13), "R4", 0);
        build(va2, 9, 9, 9, 3, leaf_w(64'h0), 64'h0030_0100);
        run_walk(va2, r52, "R4", 0);
        // R5: empty root table, invalid third-level entry
        mem.delete();
        run_walk(va2, r52, "R5", 0);
        build(va1, 9, 9, 9, 2, 64'h4000_0000_0000_1234, B2);
        run_walk(va1, r52, "R5", 0);
        // R9: request held high with other data during a walk
        lat = 0; build(va2, 9, 9, 9, 3, leaf_w(64'h0000_0BAD_F000), B2);
        run_walk(va2, r52, "R9", 1);
        finish_run();
    end

endmodule